// File: doc/BRIEF.md
# Per-Processor GPIO Interrupt Router

This block routes the interrupt requests of a 32-line GPIO bank to up to four processors. Each processor gets its own edge-cause copy, edge-enable mask and level-enable mask. Each therefore sees only the lines it has enabled, and it can acknowledge its own edges without disturbing the other processors. A shared cause register and a shared pair of masks stay in the main register window. They drive a global request line next to the per-processor lines.

The router takes the already polarity-corrected line levels and a vector of single-cycle edge events from the pin logic. It keeps all interrupt state in registers that a simple synchronous write port and a combinational read port reach. A build parameter selects one of three variants:

- **Shared only:** only the global bank exists.
- **Dual:** the global masks act as processor 0's masks. A second mask pair for processor 1 sits in the main window, and both processors use the one shared cause register.
- **Quad:** a separate per-processor window holds four independent banks.

The block has no state machine. All state is mask and cause registers.

Top module: `gpir_router`

## Requirements
- R1: After reset every cause and mask register reads zero, every `cpu_irq` bit is low and `glb_irq` is low.
- R2: In the quad variant the per-processor window (`win` = 1) places processor n's cause at byte offset 4n, its edge-enable mask at 0x10 + 4n and its level-enable mask at 0x20 + 4n. A written mask reads back unchanged.
- R3: An edge event on line b sets bit b of the global cause and of every per-processor cause copy. The bit is visible from the clock edge that samples the event.
- R4: A write to a cause register clears exactly the bits written as 0 and keeps the bits written as 1. Only the addressed copy changes.
- R5: When an edge event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R6: Request n is high when any bit of (line_level AND level mask n) OR (cause n AND edge mask n) is set. It follows `line_level` with no register delay.
- R7: In the main window (`win` = 0) the global cause is at 0x14, the edge mask at 0x18 and the level mask at 0x1C. `glb_irq` applies the R6 formula to these three registers.
- R8: In the dual variant `cpu_irq[0]` equals `glb_irq`. `cpu_irq[1]` uses the edge mask at main 0x30, the level mask at main 0x34 and the shared cause at 0x14. `cpu_irq[3:2]` stay low.
- R9: In the shared-only variant `cpu_irq[0]` equals `glb_irq`, the other bits stay low, and writes to the per-processor window change nothing; reads there return 0. Main offsets 0x30 and 0x34 read 0 in every variant except dual.
- R10: A per-processor window write to an unmapped offset (bits 1:0 not zero, offset 0x30 or above) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 1 | Write window: 0 main, 1 per-processor |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_win | input | 1 | Read window: 0 main, 1 per-processor |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Combinational read data |
| line_level | input | 32 | Polarity-corrected line levels |
| edge_evt | input | 32 | One-cycle edge event per line |
| cpu_irq | output | 4 | Summary request per processor slot |
| glb_irq | output | 1 | Request from the shared registers |

## Verification
Register writes and edge events are driven at the falling edge. They take effect at the next rising edge, and the bench updates its reference model at that same point. Cause and mask contents, and the requests derived from them, are therefore compared 1 ns after that rising edge. A change on `line_level` reaches the request outputs combinationally, within the same cycle. The read port is combinational, so readback is sampled a fraction of a nanosecond after the address is set, while writes and events are held idle. Three instances, one per variant, share the same stimulus, so one model run checks every variant.

// File: rtl/gpir_pkg.sv
package gpir_pkg;

    typedef enum logic [1:0] {
        GPIR_SHARED = 2'd0,
        GPIR_DUAL   = 2'd1,
        GPIR_QUAD   = 2'd2
    } gpir_variant_e;

    typedef enum logic [1:0] {
        GRP_CAUSE = 2'd0,
        GRP_EMASK = 2'd1,
        GRP_LMASK = 2'd2,
        GRP_NONE  = 2'd3
    } pc_group_e;

    localparam logic [7:0] MAIN_CAUSE  = 8'h14;
    localparam logic [7:0] MAIN_EMASK  = 8'h18;
    localparam logic [7:0] MAIN_LMASK  = 8'h1C;
    localparam logic [7:0] MAIN_EMASK1 = 8'h30;
    localparam logic [7:0] MAIN_LMASK1 = 8'h34;

endpackage

// File: rtl/gpir_pcwin_decode.sv
module gpir_pcwin_decode #(
    parameter int NSLOT = 4,
    parameter int AW    = 8
) (
    input  logic [AW-1:0]        addr,
    output logic                 hit,
    output logic [1:0]           slot,
    output gpir_pkg::pc_group_e  grp
);
    always_comb begin
        slot = addr[3:2];
        grp  = gpir_pkg::pc_group_e'(addr[5:4]);
        hit  = (addr[1:0] == 2'b00)
            && (int'(addr[3:2]) < NSLOT)
            && (addr[5:4] != 2'b11)
            && (addr[AW-1:6] == '0);
    end
endmodule

// File: rtl/gpir_bank.sv
module gpir_bank #(
    parameter int W         = 32,
    parameter bit OWN_CAUSE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_cause,
    input  logic         we_emask,
    input  logic         we_lmask,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] edge_evt,
    input  logic [W-1:0] line_level,
    input  logic [W-1:0] ext_cause,
    output logic [W-1:0] cause_q,
    output logic [W-1:0] emask_q,
    output logic [W-1:0] lmask_q,
    output logic         req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            emask_q <= '0;
            lmask_q <= '0;
        end else begin
            if (we_emask) emask_q <= wdata;
            if (we_lmask) lmask_q <= wdata;
        end
    end

    generate
        if (OWN_CAUSE) begin : g_own
            logic [W-1:0] cause_r;
            logic         unused_ext;
            assign unused_ext = ^ext_cause;

            // set from an event wins over a clear in the same cycle
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cause_r <= '0;
                else        cause_r <= (cause_r & (we_cause ? wdata : '1)) | edge_evt;
            end
            assign cause_q = cause_r;

            assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_evt != '0) |=> ((cause_q & $past(edge_evt)) == $past(edge_evt)));
            assert_cause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!we_cause && edge_evt == '0) |=> $stable(cause_q));
            assert_no_new_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (edge_evt == '0) |=> ((cause_q & ~$past(cause_q)) == '0));
        end else begin : g_shared
            logic unused_cause;
            assign unused_cause = we_cause ^ (^edge_evt);
            assign cause_q = ext_cause;
        end
    endgenerate

    assign req = |((line_level & lmask_q) | (cause_q & emask_q));

    assert_emask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_emask |=> $stable(emask_q));
    assert_lmask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !we_lmask |=> $stable(lmask_q));
    assert_quiet_when_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (emask_q == '0 && lmask_q == '0) |-> !req);
endmodule

// File: rtl/gpir_router.sv
module gpir_router #(
    parameter gpir_pkg::gpir_variant_e VARIANT = gpir_pkg::GPIR_QUAD,
    parameter int W     = 32,
    parameter int NSLOT = 4,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_win,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_win,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data,
    input  logic [W-1:0]  line_level,
    input  logic [W-1:0]  edge_evt,
    output logic [NSLOT-1:0] cpu_irq,
    output logic          glb_irq
);
    import gpir_pkg::*;

    localparam bit IS_QUAD = (VARIANT == GPIR_QUAD);
    localparam bit IS_DUAL = (VARIANT == GPIR_DUAL);

    // main window strobes
    logic main_wr;
    logic we_g_cause, we_g_em, we_g_lm, we_d_em1, we_d_lm1;
    assign main_wr    = wr_en && !wr_win;
    assign we_g_cause = main_wr && (wr_addr == AW'(MAIN_CAUSE));
    assign we_g_em    = main_wr && (wr_addr == AW'(MAIN_EMASK));
    assign we_g_lm    = main_wr && (wr_addr == AW'(MAIN_LMASK));
    assign we_d_em1   = main_wr && (wr_addr == AW'(MAIN_EMASK1)) && IS_DUAL;
    assign we_d_lm1   = main_wr && (wr_addr == AW'(MAIN_LMASK1)) && IS_DUAL;

    // per-processor window decode
    logic      w_hit, r_hit;
    logic [1:0] w_slot, r_slot;
    pc_group_e w_grp, r_grp;

    gpir_pcwin_decode #(.NSLOT(NSLOT), .AW(AW)) u_wdec (
        .addr(wr_addr), .hit(w_hit), .slot(w_slot), .grp(w_grp));
    gpir_pcwin_decode #(.NSLOT(NSLOT), .AW(AW)) u_rdec (
        .addr(rd_addr), .hit(r_hit), .slot(r_slot), .grp(r_grp));

    // shared bank
    logic [W-1:0] g_cause, g_em, g_lm;
    logic         g_req;

    gpir_bank #(.W(W), .OWN_CAUSE(1'b1)) u_global (
        .clk(clk), .rst_n(rst_n),
        .we_cause(we_g_cause), .we_emask(we_g_em), .we_lmask(we_g_lm),
        .wdata(wr_data), .edge_evt(edge_evt), .line_level(line_level),
        .ext_cause('0),
        .cause_q(g_cause), .emask_q(g_em), .lmask_q(g_lm), .req(g_req));

    assign glb_irq = g_req;

    logic [W-1:0] s_cause [NSLOT];
    logic [W-1:0] s_em    [NSLOT];
    logic [W-1:0] s_lm    [NSLOT];

    genvar i;
    generate
        for (i = 0; i < NSLOT; i++) begin : g_slot
            if (IS_QUAD) begin : g_quad
                logic pc_wr;
                assign pc_wr = wr_en && wr_win && w_hit && (int'(w_slot) == i);
                gpir_bank #(.W(W), .OWN_CAUSE(1'b1)) u_bank (
                    .clk(clk), .rst_n(rst_n),
                    .we_cause(pc_wr && w_grp == GRP_CAUSE),
                    .we_emask(pc_wr && w_grp == GRP_EMASK),
                    .we_lmask(pc_wr && w_grp == GRP_LMASK),
                    .wdata(wr_data), .edge_evt(edge_evt), .line_level(line_level),
                    .ext_cause('0),
                    .cause_q(s_cause[i]), .emask_q(s_em[i]), .lmask_q(s_lm[i]),
                    .req(cpu_irq[i]));

                assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_en && wr_win && !w_hit && edge_evt == '0)
                    |=> ($stable(s_cause[i]) && $stable(s_em[i]) && $stable(s_lm[i])));
            end else if (IS_DUAL && i == 1) begin : g_dual1
                gpir_bank #(.W(W), .OWN_CAUSE(1'b0)) u_bank (
                    .clk(clk), .rst_n(rst_n),
                    .we_cause(1'b0), .we_emask(we_d_em1), .we_lmask(we_d_lm1),
                    .wdata(wr_data), .edge_evt(edge_evt), .line_level(line_level),
                    .ext_cause(g_cause),
                    .cause_q(s_cause[i]), .emask_q(s_em[i]), .lmask_q(s_lm[i]),
                    .req(cpu_irq[i]));
            end else if (i == 0) begin : g_alias0
                assign s_cause[i] = '0;
                assign s_em[i]    = '0;
                assign s_lm[i]    = '0;
                assign cpu_irq[i] = g_req;
            end else begin : g_absent
                assign s_cause[i] = '0;
                assign s_em[i]    = '0;
                assign s_lm[i]    = '0;
                assign cpu_irq[i] = 1'b0;
            end
        end
    endgenerate

    // read mux
    always_comb begin
        rd_data = '0;
        if (!rd_win) begin
            if (rd_addr == AW'(MAIN_CAUSE))      rd_data = g_cause;
            else if (rd_addr == AW'(MAIN_EMASK)) rd_data = g_em;
            else if (rd_addr == AW'(MAIN_LMASK)) rd_data = g_lm;
            else if (IS_DUAL && rd_addr == AW'(MAIN_EMASK1)) rd_data = s_em[1];
            else if (IS_DUAL && rd_addr == AW'(MAIN_LMASK1)) rd_data = s_lm[1];
        end else if (IS_QUAD && r_hit) begin
            unique case (r_grp)
                GRP_CAUSE: rd_data = s_cause[r_slot];
                GRP_EMASK: rd_data = s_em[r_slot];
                GRP_LMASK: rd_data = s_lm[r_slot];
                default:   rd_data = '0;
            endcase
        end
    end

    assert_slot0_alias_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!IS_QUAD) |-> (cpu_irq[0] == glb_irq));
endmodule

// File: tb/tb_gpir_router.sv
`timescale 1ns/1ps
module tb_gpir_router;
    import gpir_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, wr_win = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_win = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] line_level = '0, edge_evt = '0;

    logic [31:0] rd_q, rd_d, rd_s;
    logic [3:0]  irq_q, irq_d, irq_s;
    logic        glb_q, glb_d, glb_s;

    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    gpir_router #(.VARIANT(GPIR_QUAD)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_win(rd_win), .rd_addr(rd_addr), .rd_data(rd_q),
        .line_level(line_level), .edge_evt(edge_evt), .cpu_irq(irq_q), .glb_irq(glb_q));
    gpir_router #(.VARIANT(GPIR_DUAL)) dut_dual (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_win(rd_win), .rd_addr(rd_addr), .rd_data(rd_d),
        .line_level(line_level), .edge_evt(edge_evt), .cpu_irq(irq_d), .glb_irq(glb_d));
    gpir_router #(.VARIANT(GPIR_SHARED)) dut_shared (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_win(rd_win), .rd_addr(rd_addr), .rd_data(rd_s),
        .line_level(line_level), .edge_evt(edge_evt), .cpu_irq(irq_s), .glb_irq(glb_s));

    // reference model
    logic [31:0] m_gc = '0, m_ge = '0, m_gl = '0, m_de1 = '0, m_dl1 = '0;
    logic [31:0] m_qc [4], m_qe [4], m_ql [4];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic reqf(logic [31:0] c, logic [31:0] e, logic [31:0] l, logic [31:0] lv);
        return |((lv & l) | (c & e));
    endfunction

    function automatic logic [31:0] exp_rd(int v, logic win, logic [7:0] a);
        if (!win) begin
            case (a)
                8'h14: return m_gc;
                8'h18: return m_ge;
                8'h1C: return m_gl;
                8'h30: return (v == 1) ? m_de1 : 32'h0;
                8'h34: return (v == 1) ? m_dl1 : 32'h0;
                default: return 32'h0;
            endcase
        end
        if (v != 2 || a[1:0] != 2'b00 || a >= 8'h30) return 32'h0;
        case (a[5:4])
            2'd0: return m_qc[a[3:2]];
            2'd1: return m_qe[a[3:2]];
            default: return m_ql[a[3:2]];
        endcase
    endfunction

    task automatic model_update(logic we, logic win, logic [7:0] a, logic [31:0] d, logic [31:0] ev);
        m_gc = (m_gc & ((we && !win && a == 8'h14) ? d : 32'hFFFF_FFFF)) | ev;
        if (we && !win && a == 8'h18) m_ge = d;
        if (we && !win && a == 8'h1C) m_gl = d;
        if (we && !win && a == 8'h30) m_de1 = d;
        if (we && !win && a == 8'h34) m_dl1 = d;
        for (int n = 0; n < 4; n++) begin
            m_qc[n] = (m_qc[n] & ((we && win && a == 8'(n*4)) ? d : 32'hFFFF_FFFF)) | ev;
            if (we && win && a == 8'(8'h10 + n*4)) m_qe[n] = d;
            if (we && win && a == 8'(8'h20 + n*4)) m_ql[n] = d;
        end
    endtask

    task automatic step(logic we, logic win, logic [7:0] a, logic [31:0] d,
                        logic [31:0] ev, logic [31:0] lv);
        @(negedge clk);
        wr_en = we; wr_win = win; wr_addr = a; wr_data = d; edge_evt = ev; line_level = lv;
        @(posedge clk);
        #1;
        model_update(we, win, a, d, ev);
        wr_en = 1'b0; edge_evt = '0;
    endtask

    task automatic check_irq(string tag);
        logic g;
        logic [3:0] eq, ed, es;
        g = reqf(m_gc, m_ge, m_gl, line_level);
        for (int n = 0; n < 4; n++) eq[n] = reqf(m_qc[n], m_qe[n], m_ql[n], line_level);
        ed = {2'b00, reqf(m_gc, m_de1, m_dl1, line_level), g};
        es = {3'b000, g};
        chk({tag, " quad irq"},  {28'h0, irq_q}, {28'h0, eq});
        chk({tag, " dual irq"},  {28'h0, irq_d}, {28'h0, ed});
        chk({tag, " shared irq"},{28'h0, irq_s}, {28'h0, es});
        chk({tag, " glb_irq"},   {29'h0, glb_q, glb_d, glb_s}, {29'h0, g, g, g});
    endtask

    task automatic check_regs(string tag);
        logic [7:0] mains [5] = '{8'h14, 8'h18, 8'h1C, 8'h30, 8'h34};
        for (int k = 0; k < 5; k++) begin
            rd_win = 1'b0; rd_addr = mains[k]; #0.1;
            chk({tag, " quad main rd"},   rd_q, exp_rd(2, 1'b0, mains[k]));
            chk({tag, " dual main rd"},   rd_d, exp_rd(1, 1'b0, mains[k]));
            chk({tag, " shared main rd"}, rd_s, exp_rd(0, 1'b0, mains[k]));
        end
        for (int k = 0; k < 13; k++) begin
            rd_win = 1'b1; rd_addr = 8'(k*4); #0.1;
            chk({tag, " quad pc rd"},   rd_q, exp_rd(2, 1'b1, 8'(k*4)));
            chk({tag, " dual pc rd"},   rd_d, 32'h0);
            chk({tag, " shared pc rd"}, rd_s, 32'h0);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] lv;
        for (int n = 0; n < 4; n++) begin m_qc[n] = '0; m_qe[n] = '0; m_ql[n] = '0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check_irq("R1 reset");
        check_regs("R1 reset");

        // R2: per-processor mask placement
        for (int n = 0; n < 4; n++) begin
            step(1'b1, 1'b1, 8'(8'h10 + n*4), 32'h0000_00A0 | (32'h1 << (n + 8)), '0, '0);
            step(1'b1, 1'b1, 8'(8'h20 + n*4), 32'h0001_0000 << n, '0, '0);
        end
        check_regs("R2 mask map");
        check_irq("R2 masks no req");

        // R7: global registers
        step(1'b1, 1'b0, 8'h18, 32'h0000_0020, '0, '0);
        step(1'b1, 1'b0, 8'h1C, 32'h0000_0400, '0, '0);
        check_regs("R7 global map");

        // R3: one edge reaches all copies
        step(1'b0, 1'b0, 8'h00, '0, 32'h0000_0020, '0);
        check_irq("R3 edge all copies");
        check_regs("R3 edge all copies");

        // R4: clear only slot 2's bit 5
        step(1'b1, 1'b1, 8'h08, ~32'h0000_0020, '0, '0);
        chk("R4 slot2 irq low", {31'h0, irq_q[2]}, 32'h0);
        check_irq("R4 isolated clear");
        check_regs("R4 isolated clear");

        // R5: simultaneous clear and event
        step(1'b1, 1'b1, 8'h00, 32'h0, 32'h0000_0080, '0);
        chk("R5 set wins", exp_rd(2, 1'b1, 8'h00), 32'h0000_0080);
        check_regs("R5 set wins");

        // R6: level path, combinational
        step(1'b1, 1'b1, 8'h00, 32'h0, '0, '0);
        step(1'b1, 1'b0, 8'h14, 32'h0, '0, '0);
        for (int n = 0; n < 4; n++) step(1'b1, 1'b1, 8'(n*4), 32'h0, '0, '0);
        check_irq("R6 all clear");
        @(negedge clk); line_level = 32'h0004_0000; #0.5;
        chk("R6 level slot2", {28'h0, irq_q}, 32'h4);
        check_irq("R6 level");
        line_level = 32'h0000_0400; #0.5;
        check_irq("R6 global level");

        // R8: dual second-processor masks
        step(1'b1, 1'b0, 8'h30, 32'h0000_8000, '0, '0);
        step(1'b1, 1'b0, 8'h34, 32'h0000_0001, '0, '0);
        check_regs("R8 dual map");
        step(1'b0, 1'b0, 8'h00, '0, 32'h0000_8000, '0);
        chk("R8 dual slot1", {28'h0, irq_d}, 32'h2);
        check_irq("R8 dual");

        // R9 / R10: ignored writes
        step(1'b1, 1'b1, 8'h30, 32'hFFFF_FFFF, '0, '0);
        step(1'b1, 1'b1, 8'h02, 32'hFFFF_FFFF, '0, '0);
        step(1'b1, 1'b1, 8'h40, 32'hFFFF_FFFF, '0, '0);
        check_regs("R10 unmapped");
        step(1'b1, 1'b1, 8'h14, 32'hFFFF_FFFF, '0, '0);
        check_regs("R9 shared ignores pc window");
        check_irq("R9 shared");

        // random mix
        for (int k = 0; k < 600; k++) begin
            logic [7:0] tbl [20] = '{8'h14, 8'h18, 8'h1C, 8'h30, 8'h34,
                                     8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18,
                                     8'h1C, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h02, 8'h40};
            int sel = int'($urandom % 20);
            logic [31:0] d = ($urandom % 4 == 0) ? $urandom : ($urandom | $urandom);
            logic [31:0] ev = $urandom & $urandom & $urandom;
            lv = $urandom & $urandom;
            step(($urandom % 3) != 0, sel >= 5, tbl[sel], d, ev, lv);
            check_irq("R6 random");
            if (k % 60 == 59) check_regs("R4 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule